// File: doc/BRIEF.md
# ROM Configuration and Access-Timing Unit

This block holds the configuration for an on-chip ROM array and times each access to it. A small register bus writes and reads three 16-bit registers: a control word and two base-address words. The control word carries a stop bit, a read-only boot-response bit, a set-once write lock, an emulation redirect bit, a two-bit array-space field and a two-bit wait-state code. The base-address words are only stored here. Address decoding against them is done elsewhere.

For every ROM access request the unit either starts a timed transfer or rejects the request with a flag. A started transfer ends with a one-cycle done strobe in its final clock. The transfer is 2, 3, 4 or 5 clocks long, as the wait-state code selects. A request is rejected with a flag in its own cycle in three cases: the array is redirected to external memory, the array is limited to program space and the request is a data access, or the request is a bootstrap-vector access while bootstrap response is disabled.

Top module: `rom_ctl_unit`

## Requirements
- R1: After reset the control word (address 0) reads `{stop=bit15, boot=bit12, lock=bit11, emul=bit10, space=bits9:8, wait=bits7:6}`. Stop equals `stop_strap` during reset, boot equals BOOT_RST, lock equals LOCK_RST, emul is 0, space equals SPACE_RST and wait equals WAIT_RST. Both base words (addresses 1 and 2) read 0. Every other bit, and address 3, reads 0.
- R2: Writing 1 to the lock bit sets it. Once set, the lock stays 1 until reset, and writes of 0 to it are ignored.
- R3: While the lock is 1 (its value before the write), writes to the space field, the wait field and both base words are discarded.
- R4: While stop is 0 (its value before the write), writes to the space field, the wait field and both base words are discarded.
- R5: Wait code 00 gives a 3-clock transfer, 01 gives 4, 10 gives 5 and 11 gives 2. The request cycle is clock 1, and done is high in the last clock. The code is captured when the request is accepted.
- R6: Done lasts exactly one cycle. Requests during a running transfer are ignored. A request held high is accepted again on the cycle after done.
- R7: With space bit 0 set to 1, a data request (`req_prog`=0) raises `not_sel` in its cycle and produces no done, while program requests still complete. Space bit 1 has no effect.
- R8: With emul set to 1, every request raises `force_ext` in its cycle and produces no done.
- R9: Bootstrap response is disabled when BOOT_RST is 1 or when `stop_strap` is 1 during reset. In that case a request with `req_boot_vec`=1 raises `boot_skip` and produces no done. Otherwise the request completes normally.
- R10: The boot bit ignores writes. The emul and stop bits accept writes whatever the lock or stop state. The flag priority is emul, then boot, then space, and at most one of done and the three flags is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_strap | input | 1 | Stop value captured during reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` (combinational) |
| req | input | 1 | ROM access request |
| req_prog | input | 1 | 1 = program-space access, 0 = data |
| req_boot_vec | input | 1 | Access hits a bootstrap word during reset-vector fetch |
| done | output | 1 | Transfer completes this clock |
| force_ext | output | 1 | Request redirected externally |
| not_sel | output | 1 | Data request refused by program-only space |
| boot_skip | output | 1 | Bootstrap-vector request not answered |

## Verification
The timing assertions assume that the requester holds `req_prog` and `req_boot_vec` steady for the cycle in which `req` is high. They also assume that no wait-state code can make a transfer shorter than two clocks, so done can never be followed directly by another done. The register assertions compare each protected field with its value one cycle earlier. They therefore rely on writes being single-cycle strobes whose gating uses the lock and stop values from before the write. The stimulus drives every input on the falling edge and keeps each write to one cycle. It releases `req` after its acceptance cycle, except in the one scenario that holds it high on purpose to show back-to-back acceptance.

// File: rtl/rom_ctl_pkg.sv
package rom_ctl_pkg;

    localparam int REG_W       = 16;
    localparam int BIT_STOP    = 15;
    localparam int BIT_BOOT    = 12;
    localparam int BIT_LOCK    = 11;
    localparam int BIT_EMUL    = 10;
    localparam int BIT_SPACE   = 8;
    localparam int BIT_WAIT    = 6;

    localparam int ADR_CTRL    = 0;
    localparam int ADR_BASE_HI = 1;
    localparam int ADR_BASE_LO = 2;
    localparam int NUM_BASE    = 2;

    localparam int MAX_CLOCKS  = 5;
    localparam int CNT_W       = $clog2(MAX_CLOCKS);

    typedef enum logic [1:0] {
        WS_NONE = 2'b00,
        WS_ONE  = 2'b01,
        WS_TWO  = 2'b10,
        WS_FAST = 2'b11
    } wait_code_e;

    typedef struct packed {
        logic       stop;
        logic       lock;
        logic       emul;
        logic [1:0] space;
        wait_code_e wcode;
    } ctrl_s;

    // Clocks per transfer for a wait-state code.
    function automatic logic [CNT_W-1:0] clocks_for(input wait_code_e w);
        case (w)
            WS_NONE: clocks_for = CNT_W'(3);
            WS_ONE:  clocks_for = CNT_W'(4);
            WS_TWO:  clocks_for = CNT_W'(5);
            default: clocks_for = CNT_W'(2);
        endcase
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_s c, input logic boot);
        logic [REG_W-1:0] v;
        v                   = '0;
        v[BIT_STOP]         = c.stop;
        v[BIT_BOOT]         = boot;
        v[BIT_LOCK]         = c.lock;
        v[BIT_EMUL]         = c.emul;
        v[BIT_SPACE +: 2]   = c.space;
        v[BIT_WAIT  +: 2]   = c.wcode;
        return v;
    endfunction

endpackage

// File: rtl/rom_cfg_regs.sv
module rom_cfg_regs
    import rom_ctl_pkg::*;
#(
    parameter int         DATA_W    = REG_W,
    parameter int         ADDR_W    = 2,
    parameter logic       BOOT_RST  = 1'b0,
    parameter logic       LOCK_RST  = 1'b0,
    parameter logic [1:0] SPACE_RST = 2'b00,
    parameter logic [1:0] WAIT_RST  = 2'b00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stop_strap,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output ctrl_s             ctrl,
    output logic              boot_dis
);

    ctrl_s             ctrl_q;
    logic              boot_dis_q;
    logic              prot_ok;
    logic              wr_ctrl;
    logic [DATA_W-1:0] base_q [NUM_BASE];

    // Protected fields use the lock/stop values held before this write.
    assign prot_ok = !ctrl_q.lock && ctrl_q.stop;
    assign wr_ctrl = wr_en && (addr == ADDR_W'(ADR_CTRL));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.stop  <= stop_strap;
            ctrl_q.lock  <= LOCK_RST;
            ctrl_q.emul  <= 1'b0;
            ctrl_q.space <= SPACE_RST;
            ctrl_q.wcode <= wait_code_e'(WAIT_RST);
            boot_dis_q   <= BOOT_RST | stop_strap;
        end else if (wr_ctrl) begin
            ctrl_q.stop <= wr_data[BIT_STOP];
            ctrl_q.emul <= wr_data[BIT_EMUL];
            if (wr_data[BIT_LOCK])
                ctrl_q.lock <= 1'b1;
            if (prot_ok) begin
                ctrl_q.space <= wr_data[BIT_SPACE +: 2];
                ctrl_q.wcode <= wait_code_e'(wr_data[BIT_WAIT +: 2]);
            end
        end
    end

    for (genvar g = 0; g < NUM_BASE; g++) begin : g_base
        localparam int MY_ADR = (g == 0) ? ADR_BASE_HI : ADR_BASE_LO;
        always_ff @(posedge clk) begin
            if (rst)
                base_q[g] <= '0;
            else if (wr_en && prot_ok && addr == ADDR_W'(MY_ADR))
                base_q[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            ADDR_W'(ADR_CTRL):    rd_data = DATA_W'(pack_ctrl(ctrl_q, BOOT_RST));
            ADDR_W'(ADR_BASE_HI): rd_data = base_q[0];
            ADDR_W'(ADR_BASE_LO): rd_data = base_q[1];
            default:              rd_data = '0;
        endcase
    end

    assign ctrl     = ctrl_q;
    assign boot_dis = boot_dis_q;

    assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.lock |=> ctrl_q.lock);

    assert_locked_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.lock |=> ($stable(ctrl_q.wcode) && $stable(ctrl_q.space)
                         && $stable(base_q[0]) && $stable(base_q[1])));

    assert_stopped_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.stop |=> ($stable(ctrl_q.wcode) && $stable(ctrl_q.space)
                          && $stable(base_q[0]) && $stable(base_q[1])));

    assert_bootdis_stable_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(boot_dis_q));

endmodule

// File: rtl/rom_access_timer.sv
module rom_access_timer
    import rom_ctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_s ctrl,
    input  logic  boot_dis,
    input  logic  req,
    input  logic  req_prog,
    input  logic  req_boot_vec,
    output logic  done,
    output logic  force_ext,
    output logic  not_sel,
    output logic  boot_skip
);

    logic             busy_q;
    logic [CNT_W-1:0] left_q;
    logic             idle_req;
    logic             accept;

    assign idle_req  = req && !busy_q;
    // Priority: emulation redirect, then bootstrap suppression, then space.
    assign force_ext = idle_req && ctrl.emul;
    assign boot_skip = idle_req && !ctrl.emul && req_boot_vec && boot_dis;
    assign not_sel   = idle_req && !ctrl.emul && !(req_boot_vec && boot_dis)
                       && !req_prog && ctrl.space[0];
    assign accept    = idle_req && !force_ext && !boot_skip && !not_sel;
    assign done      = busy_q && (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            left_q <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            left_q <= clocks_for(ctrl.wcode) - CNT_W'(2);
        end else if (busy_q) begin
            if (left_q == '0)
                busy_q <= 1'b0;
            else
                left_q <= left_q - CNT_W'(1);
        end
    end

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !done) |=> busy_q);

    assert_space_reject_R7: assert property (@(posedge clk) disable iff (rst)
        not_sel |=> !busy_q);

    assert_emul_reject_R8: assert property (@(posedge clk) disable iff (rst)
        force_ext |=> !busy_q);

    assert_boot_reject_R9: assert property (@(posedge clk) disable iff (rst)
        boot_skip |=> !busy_q);

    assert_flags_excl_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({force_ext, not_sel, boot_skip, done}));

endmodule

// File: rtl/rom_ctl_unit.sv
module rom_ctl_unit
    import rom_ctl_pkg::*;
#(
    parameter int         DATA_W    = REG_W,
    parameter int         ADDR_W    = 2,
    parameter logic       BOOT_RST  = 1'b0,
    parameter logic       LOCK_RST  = 1'b0,
    parameter logic [1:0] SPACE_RST = 2'b00,
    parameter logic [1:0] WAIT_RST  = 2'b00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stop_strap,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              req,
    input  logic              req_prog,
    input  logic              req_boot_vec,
    output logic              done,
    output logic              force_ext,
    output logic              not_sel,
    output logic              boot_skip
);

    ctrl_s ctrl;
    logic  boot_dis;

    rom_cfg_regs #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .BOOT_RST (BOOT_RST),
        .LOCK_RST (LOCK_RST),
        .SPACE_RST(SPACE_RST),
        .WAIT_RST (WAIT_RST)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .stop_strap(stop_strap),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .ctrl      (ctrl),
        .boot_dis  (boot_dis)
    );

    rom_access_timer u_timer (
        .clk         (clk),
        .rst         (rst),
        .ctrl        (ctrl),
        .boot_dis    (boot_dis),
        .req         (req),
        .req_prog    (req_prog),
        .req_boot_vec(req_boot_vec),
        .done        (done),
        .force_ext   (force_ext),
        .not_sel     (not_sel),
        .boot_skip   (boot_skip)
    );

endmodule

// File: tb/rom_ctl_unit_tb.sv
module rom_ctl_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stop_strap = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        req = 1'b0, req_prog = 1'b1, req_boot_vec = 1'b0;
    logic        done, force_ext, not_sel, boot_skip;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rom_ctl_unit u_dut (
        .clk(clk), .rst(rst), .stop_strap(stop_strap),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .req(req), .req_prog(req_prog), .req_boot_vec(req_boot_vec),
        .done(done), .force_ext(force_ext), .not_sel(not_sel), .boot_skip(boot_skip)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // stop=15 boot=12 lock=11 emul=10 space=9:8 wait=7:6
    function automatic logic [15:0] cw(input logic stop, input logic lock, input logic emul,
                                       input logic [1:0] sp, input logic [1:0] wt);
        cw = '0;
        cw[15] = stop; cw[11] = lock; cw[10] = emul; cw[9:8] = sp; cw[7:6] = wt;
    endfunction

    task automatic do_reset(input logic strap);
        @(negedge clk); rst = 1'b1; stop_strap = strap;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; #1 d = rd_data;
    endtask

    // Returns the clock index of done (0 if none) and the request-cycle flags.
    task automatic run_req(input logic prog, input logic bv, output int clocks,
                           output logic [2:0] flags);
        @(negedge clk); req = 1'b1; req_prog = prog; req_boot_vec = bv;
        #1 flags = {force_ext, not_sel, boot_skip};
        clocks = 0;
        @(negedge clk); req = 1'b0; req_prog = 1'b1; req_boot_vec = 1'b0;
        for (int i = 2; i <= 8; i++) begin
            #1 if (done && clocks == 0) clocks = i;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        logic [15:0] d;
        do_reset(1'b0);
        rd(2'd0, d); check("R1 ctrl reset", d, 16'h0000);
        rd(2'd1, d); check("R1 base hi reset", d, 16'h0000);
        rd(2'd2, d); check("R1 base lo reset", d, 16'h0000);
        rd(2'd3, d); check("R1 unused addr", d, 16'h0000);
        #1 check("R1 done idle", {15'd0, done}, 16'd0);
    endtask

    task automatic t_stop_gate();
        logic [15:0] d;
        wr(2'd0, cw(1'b0, 1'b0, 1'b0, 2'b01, 2'b10));
        rd(2'd0, d); check("R4 fields blocked when stop=0", d, 16'h0000);
        wr(2'd1, 16'hBEEF);
        rd(2'd1, d); check("R4 base blocked when stop=0", d, 16'h0000);
        wr(2'd0, cw(1'b1, 1'b0, 1'b0, 2'b00, 2'b00));
        rd(2'd0, d); check("R10 stop writable", d, 16'h8000);
        wr(2'd0, cw(1'b1, 1'b0, 1'b0, 2'b00, 2'b00) | 16'h1000);
        rd(2'd0, d); check("R10 boot bit read-only", d, 16'h8000);
        wr(2'd1, 16'hBEEF); wr(2'd2, 16'h1234);
        rd(2'd1, d); check("R4 base hi written with stop=1", d, 16'hBEEF);
        rd(2'd2, d); check("R4 base lo written with stop=1", d, 16'h1234);
    endtask

    task automatic t_wait_codes();
        int c; logic [2:0] f;
        int exp_clk [4] = '{3, 4, 5, 2};
        for (int w = 0; w < 4; w++) begin
            wr(2'd0, cw(1'b1, 1'b0, 1'b0, 2'b00, 2'(w)));
            run_req(1'b1, 1'b0, c, f);
            check($sformatf("R5 clocks for code %0d", w), 16'(c), 16'(exp_clk[w]));
        end
    endtask

    task automatic t_held_req();
        logic [7:0] pat; int pulses;
        wr(2'd0, cw(1'b1, 1'b0, 1'b0, 2'b00, 2'b00));
        pat = '0;
        @(negedge clk); req = 1'b1; req_prog = 1'b1;
        for (int i = 1; i <= 7; i++) begin
            #1 pat[i] = done;
            @(negedge clk);
        end
        req = 1'b0;
        pulses = $countones(pat);
        check("R6 held request done pattern", {8'd0, pat}, 16'b0100_1000);
        check("R6 done pulse count", 16'(pulses), 16'd2);
        @(negedge clk); @(negedge clk);
    endtask

    task automatic t_space();
        int c; logic [2:0] f;
        wr(2'd0, cw(1'b1, 1'b0, 1'b0, 2'b01, 2'b11));
        run_req(1'b0, 1'b0, c, f);
        check("R7 data refused flags", {13'd0, f}, 16'b010);
        check("R7 data refused no done", 16'(c), 16'd0);
        run_req(1'b1, 1'b0, c, f);
        check("R7 program allowed", 16'(c), 16'd2);
        wr(2'd0, cw(1'b1, 1'b0, 1'b0, 2'b10, 2'b11));
        run_req(1'b0, 1'b0, c, f);
        check("R7 space bit1 no effect", 16'(c), 16'd2);
    endtask

    task automatic t_emul();
        int c; logic [2:0] f;
        wr(2'd0, cw(1'b1, 1'b0, 1'b1, 2'b01, 2'b11));
        run_req(1'b0, 1'b0, c, f);
        check("R8 R10 emul flag wins", {13'd0, f}, 16'b100);
        check("R8 emul no done", 16'(c), 16'd0);
        wr(2'd0, cw(1'b1, 1'b0, 1'b0, 2'b00, 2'b11));
    endtask

    task automatic t_boot_enabled();
        int c; logic [2:0] f;
        run_req(1'b1, 1'b1, c, f);
        check("R9 boot vector answered", 16'(c), 16'd2);
        check("R9 no boot_skip", {13'd0, f}, 16'b000);
    endtask

    task automatic t_lock();
        logic [15:0] d;
        wr(2'd0, cw(1'b1, 1'b1, 1'b0, 2'b00, 2'b10));
        rd(2'd0, d); check("R2 lock set, same-write wait taken", d, 16'h8880);
        wr(2'd0, cw(1'b1, 1'b0, 1'b1, 2'b01, 2'b01));
        rd(2'd0, d); check("R2 R3 lock sticky, fields kept, emul free", d, 16'h8C80);
        wr(2'd1, 16'h5555);
        rd(2'd1, d); check("R3 base blocked when locked", d, 16'hBEEF);
    endtask

    task automatic t_boot_strap();
        int c; logic [2:0] f; logic [15:0] d;
        do_reset(1'b1);
        rd(2'd0, d); check("R1 stop from strap", d, 16'h8000);
        run_req(1'b1, 1'b1, c, f);
        check("R9 boot vector skipped", {13'd0, f}, 16'b001);
        check("R9 skipped no done", 16'(c), 16'd0);
        run_req(1'b1, 1'b0, c, f);
        check("R9 normal access still served", 16'(c), 16'd3);
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_stop_gate();
                t_wait_codes();
                t_held_req();
                t_space();
                t_emul();
                t_boot_enabled();
                t_lock();
                t_boot_strap();
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule